// File: doc/BRIEF.md
# Programmable System Interrupt Router

The router gathers peripheral interrupt lines, organised in banks of 32, and drives nine core priority outputs for levels 7 through 15. Each line passes through a two-flop synchroniser into a pending-status bit. A per-bank enable mask gates the pending bit. A 4-bit steering field, one per line, chooses the level that the line drives. Each core output is the OR of every enabled, pending line whose field selects that level.

Software programs the block through a word-addressed register port. The port accepts 16-bit and 32-bit accesses and answers each one with a response code. Requests use a valid/ready handshake and responses use a second valid/ready pair. While a response waits with `rsp_ready` low, it holds steady and no new request is accepted (`req_ready` low). A request is accepted on any edge where `req_valid` and `req_ready` are both high. Its response appears in the following cycle.

Word address map:

| Word address | Register |
|---|---|
| 0 | reset-control scratch (16 bit) |
| 1 | configuration scratch (16 bit) |
| 2 | vector scratch (16 bit) |
| 8 + b | enable mask of bank b |
| 12 + b | pending status of bank b (read-only) |
| 16 + b | wake enable of bank b |
| 32 + 4b + k | steering word k of bank b |

Every other address is unmapped.

Top module: `irq_steer_top`

## Requirements
- R1: A core output is asserted only while some line has both its pending-status bit and its mask bit set. Clearing the mask bit removes that line's contribution.
- R2: Line n of bank b (global input index 32b+n) takes its steering field from steering word 32+4b+n/8, bits [(n%8)*4+3:(n%8)*4]. A field value v drives `core_lvl_o[v]`, which is priority level 7+v. Several lines that select the same level are ORed onto that output.
- R3: Field values 9 to 15 drive no output. Value 8 drives `core_lvl_o[8]`.
- R4: Bank 1 uses its own mask (word 9), its own status (word 13) and steering words 36 to 39. Bank 0 registers have no effect on bank 1 lines.
- R5: A write to a status word is accepted with response code 0 and leaves the status word unchanged.
- R6: After reset: masks, status, steering words and scratch registers are 0, wake-enable words are 0xFFFFFFFF, all core outputs are low, `rsp_valid` is 0 and `req_ready` is 1.
- R7: `req_bytes` must be 2 or 4. Any other value returns response code 1, even at an unmapped address, and a write with such a width changes nothing.
- R8: An access to an unmapped address returns response code 2. A read of such an address returns zero data.
- R9: The three scratch registers are 16 bits wide. They store `req_wdata[15:0]`, and a read returns bits 31:16 as zero at either width.
- R10: A mask write takes effect on the outputs in the cycle right after the accepting edge.
- R11: An input change appears in the status word, and on the outputs, after exactly three rising edges: two synchroniser stages and then the status register.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response data and response code hold steady, and a presented request is not accepted.
- R13: A 2-byte write to a 32-bit register replaces only bits 15:0. A 2-byte read returns bits 15:0 with the upper half zero. Response code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_BANKS*32 | Level-sensitive peripheral interrupt lines |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_bytes | input | 3 | Access width in bytes (2 or 4 legal) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| rsp_code | output | 2 | 0 ok, 1 bad width, 2 unmapped |
| core_lvl_o | output | 9 | Core priority outputs, bit k = level 7+k |

## Verification
The bench places steering fields at the extremes of both banks. A wrong nibble offset or word index would then light the wrong level, or drive a bank 1 line from bank 0 registers. It checks field values 8 and 9 against each other, which catches an off-by-one in the level range. It sends a bad width to an unmapped address, which exposes reversed error priority. It also checks 16-bit scratch reads after an all-ones 32-bit write, and writes to the status words, to expose wide storage and writable status. Timing is checked to the cycle, both for input synchronisation and for mask writes, and back-pressure is held for several cycles so that a response that is lost or overwritten would show.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int STEER_W        = 4;
  localparam int NUM_LEVELS     = 9;
  localparam int WORDS_PER_BANK = LINES_PER_BANK * STEER_W / 32;
  localparam int NUM_SCRATCH    = 3;

  localparam int ADR_SCRATCH_LAST = 2;
  localparam int ADR_MASK         = 8;
  localparam int ADR_STAT         = 12;
  localparam int ADR_WAKE         = 16;
  localparam int ADR_STEER        = 32;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_BADSIZE = 2'd1,
    RSP_NOREG   = 2'd2
  } rsp_code_e;

  typedef enum logic [2:0] {
    K_NONE, K_SCRATCH, K_MASK, K_STAT, K_WAKE, K_STEER
  } reg_kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int LINES  = 64,
  parameter int NLEV   = 9,
  parameter int FIELDW = 4
) (
  input  logic [LINES-1:0]        pend_i,
  input  logic [LINES*FIELDW-1:0] steer_i,
  output logic [NLEV-1:0]         lvl_o
);
  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    logic [LINES-1:0] hit;
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign hit[i] = pend_i[i] && (steer_i[i*FIELDW +: FIELDW] == FIELDW'(l));
    end
    assign lvl_o[l] = |hit;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_steer_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int AW        = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [AW-1:0]                      req_addr,
  input  logic [2:0]                         req_bytes,
  input  logic [31:0]                        req_wdata,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [31:0]                        rsp_rdata,
  output logic [1:0]                         rsp_code,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] status_i,
  output logic [NUM_BANKS*LINES_PER_BANK-1:0] mask_o,
  output logic [NUM_BANKS*WORDS_PER_BANK*32-1:0] steer_o
);
  localparam int NSTEER = NUM_BANKS * WORDS_PER_BANK;
  localparam int SW     = $clog2(NSTEER) + 1;

  logic [31:0] mask_q  [NUM_BANKS];
  logic [31:0] wake_q  [NUM_BANKS];
  logic [31:0] steer_q [NSTEER];
  logic [15:0] scr_q   [NUM_SCRATCH];

  reg_kind_e   kind;
  logic [SW-1:0] sel;
  logic [31:0] rd_full, rd_val;
  rsp_code_e   code_n;
  logic        size_ok, half, accept, wr_en;

  function automatic logic [31:0] merge(input logic [31:0] old_v,
                                        input logic [31:0] new_v,
                                        input logic        lo_only);
    return lo_only ? {old_v[31:16], new_v[15:0]} : new_v;
  endfunction

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign size_ok   = (req_bytes == 3'd2) || (req_bytes == 3'd4);
  assign half      = (req_bytes == 3'd2);

  always_comb begin
    int a;
    a    = int'(req_addr);
    kind = K_NONE;
    sel  = '0;
    if (a <= ADR_SCRATCH_LAST) begin
      kind = K_SCRATCH; sel = SW'(a);
    end else if (a >= ADR_MASK && a < ADR_MASK + NUM_BANKS) begin
      kind = K_MASK; sel = SW'(a - ADR_MASK);
    end else if (a >= ADR_STAT && a < ADR_STAT + NUM_BANKS) begin
      kind = K_STAT; sel = SW'(a - ADR_STAT);
    end else if (a >= ADR_WAKE && a < ADR_WAKE + NUM_BANKS) begin
      kind = K_WAKE; sel = SW'(a - ADR_WAKE);
    end else if (a >= ADR_STEER && a < ADR_STEER + NSTEER) begin
      kind = K_STEER; sel = SW'(a - ADR_STEER);
    end
  end

  always_comb begin
    rd_full = '0;
    case (kind)
      K_SCRATCH: for (int s = 0; s < NUM_SCRATCH; s++)
                   if (sel == SW'(s)) rd_full = {16'h0, scr_q[s]};
      K_MASK:    for (int b = 0; b < NUM_BANKS; b++)
                   if (sel == SW'(b)) rd_full = mask_q[b];
      K_STAT:    for (int b = 0; b < NUM_BANKS; b++)
                   if (sel == SW'(b)) rd_full = status_i[b*32 +: 32];
      K_WAKE:    for (int b = 0; b < NUM_BANKS; b++)
                   if (sel == SW'(b)) rd_full = wake_q[b];
      K_STEER:   for (int k = 0; k < NSTEER; k++)
                   if (sel == SW'(k)) rd_full = steer_q[k];
      default:   rd_full = '0;
    endcase
    rd_val = half ? {16'h0, rd_full[15:0]} : rd_full;
    if (!size_ok)             code_n = RSP_BADSIZE;
    else if (kind == K_NONE)  code_n = RSP_NOREG;
    else                      code_n = RSP_OK;
  end

  assign wr_en = accept && req_write && (code_n == RSP_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_code  <= RSP_OK;
      for (int b = 0; b < NUM_BANKS; b++) begin
        mask_q[b] <= '0;
        wake_q[b] <= '1;
      end
      for (int k = 0; k < NSTEER; k++) steer_q[k] <= '0;
      for (int s = 0; s < NUM_SCRATCH; s++) scr_q[s] <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_code  <= code_n;
        rsp_rdata <= (req_write || code_n != RSP_OK) ? 32'h0 : rd_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (wr_en) begin
        for (int s = 0; s < NUM_SCRATCH; s++)
          if (kind == K_SCRATCH && sel == SW'(s)) scr_q[s] <= req_wdata[15:0];
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (kind == K_MASK && sel == SW'(b)) mask_q[b] <= merge(mask_q[b], req_wdata, half);
          if (kind == K_WAKE && sel == SW'(b)) wake_q[b] <= merge(wake_q[b], req_wdata, half);
        end
        for (int k = 0; k < NSTEER; k++)
          if (kind == K_STEER && sel == SW'(k)) steer_q[k] <= merge(steer_q[k], req_wdata, half);
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask_out
    assign mask_o[b*32 +: 32] = mask_q[b];
  end
  for (genvar k = 0; k < NSTEER; k++) begin : g_steer_out
    assign steer_o[k*32 +: 32] = steer_q[k];
  end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_i,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [5:0]                         req_addr,
  input  logic [2:0]                         req_bytes,
  input  logic [31:0]                        req_wdata,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [31:0]                        rsp_rdata,
  output logic [1:0]                         rsp_code,
  output logic [NUM_LEVELS-1:0]              core_lvl_o
);
  localparam int LINES = NUM_BANKS * LINES_PER_BANK;

  logic [LINES-1:0]         irq_sync_w;
  logic [LINES-1:0]         status_q;
  logic [LINES-1:0]         mask_w;
  logic [LINES*STEER_W-1:0] steer_w;

  irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_i), .q_o(irq_sync_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= irq_sync_w;
  end

  irq_regfile #(.NUM_BANKS(NUM_BANKS), .AW(6)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_code(rsp_code), .status_i(status_q), .mask_o(mask_w), .steer_o(steer_w)
  );

  irq_route #(.LINES(LINES), .NLEV(NUM_LEVELS), .FIELDW(STEER_W)) u_route (
    .pend_i(status_q & mask_w), .steer_i(steer_w), .lvl_o(core_lvl_o)
  );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_i,
  input logic                               req_valid,
  input logic                               req_ready,
  input logic                               req_write,
  input logic [5:0]                         req_addr,
  input logic [2:0]                         req_bytes,
  input logic                               rsp_valid,
  input logic                               rsp_ready,
  input logic [31:0]                        rsp_rdata,
  input logic [1:0]                         rsp_code,
  input logic [NUM_LEVELS-1:0]              core_lvl_o,
  input logic [NUM_BANKS*LINES_PER_BANK-1:0] status_q,
  input logic [NUM_BANKS*LINES_PER_BANK-1:0] mask_w
);
  logic [1:0] age;
  logic       hs, width_bad, mapped, scratch_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    int a;
    a = int'(req_addr);
    mapped = (a < 3) || (a >= 8 && a < 8 + NUM_BANKS) || (a >= 12 && a < 12 + NUM_BANKS)
          || (a >= 16 && a < 16 + NUM_BANKS) || (a >= 32 && a < 32 + 4*NUM_BANKS);
    scratch_rd = (a < 3);
  end

  assign hs        = req_valid && req_ready;
  assign width_bad = (req_bytes != 3'd2) && (req_bytes != 3'd4);

  AST_GATED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_lvl_o != '0) |-> ((status_q & mask_w) != '0));  // R1

  AST_WIDTH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && width_bad) |=> (rsp_valid && rsp_code == 2'd1));  // R7

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !width_bad && !req_write && !mapped) |=> (rsp_rdata == 32'h0 && rsp_code == 2'd2));  // R8

  AST_SCRATCH_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !width_bad && !req_write && scratch_rd) |=> (rsp_rdata[31:16] == 16'h0));  // R9

  AST_RSP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_code)));  // R12

  if (SYNC_STAGES == 2) begin : g_lat
    AST_STATUS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (status_q == $past(irq_i, 3)));  // R11
  end
endmodule

bind irq_steer_top irq_steer_chk #(.NUM_BANKS(NUM_BANKS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_code(rsp_code), .core_lvl_o(core_lvl_o),
  .status_q(status_q), .mask_w(mask_w)
);

// File: tb/irq_steer_top_test.sv
module irq_steer_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_i = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [5:0]  req_addr = '0;
  logic [2:0]  req_bytes = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_code;
  logic [8:0]  core_lvl_o;

  int tests = 0, fails = 0;
  bit done = 0;

  irq_steer_top uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_code(rsp_code),
    .core_lvl_o(core_lvl_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [5:0] adr, input logic [2:0] nb,
                     input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] code);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = adr; req_bytes = nb; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; code = rsp_code;
    req_valid = 1'b0;
  endtask

  task automatic wr32(input logic [5:0] adr, input logic [31:0] wd);
    logic [31:0] rd; logic [1:0] c;
    bus(1'b1, adr, 3'd4, wd, rd, c);
  endtask

  task automatic set_irq(input logic [63:0] v);
    @(negedge clk); irq_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic [1:0] c;
    check("R6 core_lvl", 32'(core_lvl_o), 0);
    check("R6 req_ready", 32'(req_ready), 1);
    check("R6 rsp_valid", 32'(rsp_valid), 0);
    bus(1'b0, 6'd8, 3'd4, 0, rd, c);  check("R6 mask0", rd, 0);
    bus(1'b0, 6'd13, 3'd4, 0, rd, c); check("R6 status1", rd, 0);
    bus(1'b0, 6'd17, 3'd4, 0, rd, c); check("R6 wake1", rd, 32'hFFFF_FFFF);
    bus(1'b0, 6'd35, 3'd4, 0, rd, c); check("R6 steer3", rd, 0);
    bus(1'b0, 6'd2, 3'd4, 0, rd, c);  check("R6 scratch", rd, 0);
  endtask

  task automatic t_forward;
    wr32(6'd32, 32'h0030_0000);             // line 5 -> field 3
    wr32(6'd35, 32'h3000_0000);             // line 31 -> field 3
    wr32(6'd8, 32'h8000_0020);
    set_irq(64'h0000_0000_0000_0020);
    check("R2 line5 level10", 32'(core_lvl_o), 32'h008);
    set_irq(64'h0000_0000_8000_0020);
    check("R2 OR of two lines", 32'(core_lvl_o), 32'h008);
    wr32(6'd8, 32'h0);
    check("R1 masked off", 32'(core_lvl_o), 0);
    set_irq(64'h0);
  endtask

  task automatic t_field_edges;
    wr32(6'd32, 32'h0000_0098);             // line0 -> 8, line1 -> 9
    wr32(6'd8, 32'h0000_0003);
    set_irq(64'h2);
    check("R3 field 9 no output", 32'(core_lvl_o), 0);
    set_irq(64'h1);
    check("R3 field 8 top level", 32'(core_lvl_o), 32'h100);
    wr32(6'd8, 32'h0);
    set_irq(64'h0);
    check("R1 idle", 32'(core_lvl_o), 0);
  endtask

  task automatic t_bank1;
    logic [31:0] rd; logic [1:0] c;
    wr32(6'd38, 32'h0000_0060);             // line 32+17 -> field 6
    wr32(6'd34, 32'h0000_0010);             // bank0 line17 -> field 1
    wr32(6'd8, 32'hFFFF_FFFF);
    set_irq(64'h0002_0000_0000_0000);
    check("R4 bank0 mask does not enable bank1", 32'(core_lvl_o), 0);
    bus(1'b0, 6'd13, 3'd4, 0, rd, c); check("R4 status1 bit17", rd, 32'h0002_0000);
    bus(1'b0, 6'd12, 3'd4, 0, rd, c); check("R4 status0 clear", rd, 0);
    wr32(6'd9, 32'h0002_0000);
    check("R4 bank1 level13", 32'(core_lvl_o), 32'h040);
    wr32(6'd8, 0); wr32(6'd9, 0);
    set_irq(64'h0);
  endtask

  task automatic t_status_ro;
    logic [31:0] rd; logic [1:0] c;
    set_irq(64'h0000_0000_0000_0404);
    bus(1'b1, 6'd12, 3'd4, 32'hFFFF_FFFF, rd, c); check("R5 write code", 32'(c), 0);
    bus(1'b0, 6'd12, 3'd4, 0, rd, c);             check("R5 status kept", rd, 32'h0000_0404);
    set_irq(64'h0);
  endtask

  task automatic t_width;
    logic [31:0] rd; logic [1:0] c;
    bus(1'b0, 6'd5, 3'd3, 0, rd, c);              check("R7 width over hole", 32'(c), 1);
    bus(1'b1, 6'd8, 3'd1, 32'hFFFF_FFFF, rd, c);  check("R7 byte write code", 32'(c), 1);
    bus(1'b0, 6'd8, 3'd4, 0, rd, c);              check("R7 mask unchanged", rd, 0);
  endtask

  task automatic t_hole;
    logic [31:0] rd; logic [1:0] c;
    bus(1'b0, 6'd10, 3'd4, 0, rd, c);
    check("R8 hole data", rd, 0); check("R8 hole code", 32'(c), 2);
    bus(1'b0, 6'd40, 3'd2, 0, rd, c);             check("R8 hole 16b code", 32'(c), 2);
  endtask

  task automatic t_scratch;
    logic [31:0] rd; logic [1:0] c;
    bus(1'b1, 6'd1, 3'd4, 32'hFFFF_FFFF, rd, c);  check("R9 write ok", 32'(c), 0);
    bus(1'b0, 6'd1, 3'd4, 0, rd, c);              check("R9 16-bit wide", rd, 32'h0000_FFFF);
  endtask

  task automatic t_half;
    logic [31:0] rd; logic [1:0] c;
    wr32(6'd16, 32'h1234_5678);
    bus(1'b1, 6'd16, 3'd2, 32'hFFFF_ABCD, rd, c); check("R13 half write code", 32'(c), 0);
    bus(1'b0, 6'd16, 3'd4, 0, rd, c);             check("R13 low half only", rd, 32'h1234_ABCD);
    bus(1'b0, 6'd16, 3'd2, 0, rd, c);             check("R13 half read", rd, 32'h0000_ABCD);
  endtask

  task automatic t_mask_now;
    wr32(6'd33, 32'h0000_0007);             // line 8 -> field 7
    set_irq(64'h100);
    check("R10 before mask", 32'(core_lvl_o), 0);
    wr32(6'd8, 32'h100);
    check("R10 next cycle", 32'(core_lvl_o), 32'h080);
    wr32(6'd8, 0);
    set_irq(64'h0);
  endtask

  task automatic t_sync;
    wr32(6'd32, 32'h0);
    wr32(6'd8, 32'h1);
    @(negedge clk); irq_i = 64'h1;
    repeat (2) @(negedge clk);
    check("R11 not yet after 2 edges", 32'(core_lvl_o), 0);
    @(negedge clk);
    check("R11 after 3 edges", 32'(core_lvl_o), 32'h001);
    irq_i = 64'h0;
    repeat (2) @(negedge clk);
    check("R11 drop held 2 edges", 32'(core_lvl_o), 32'h001);
    @(negedge clk);
    check("R11 drop after 3 edges", 32'(core_lvl_o), 0);
    wr32(6'd8, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd17; req_bytes = 3'd4;
    @(negedge clk);
    req_addr = 6'd9;                        // second request presented while stalled
    check("R12 resp valid", 32'(rsp_valid), 1);
    check("R12 req_ready low", 32'(req_ready), 0);
    repeat (2) @(negedge clk);
    check("R12 data held", rsp_rdata, 32'hFFFF_FFFF);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 next response", rsp_rdata, 0);
    check("R12 next valid", 32'(rsp_valid), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_field_edges();
    t_bank1();
    t_status_ro();
    t_width();
    t_hole();
    t_scratch();
    t_half();
    t_mask_now();
    t_sync();
    t_stall();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule